// File: doc/BRIEF.md
# Banked Programmable Baud-Rate Generator

This block holds eight independent clock generators for serial channels. Each generator is set up by one 32-bit configuration word. That word turns the generator on or off and picks its source: the system clock or one of two external clock pins. It can route the source through a fixed divide-by-16 prescaler. It also holds a 12-bit count that is the divisor minus one. Every generator drives two outputs. One is a single-cycle tick at the divided rate, meant for receivers that oversample. The other is a square clock that toggles on every tick.

Software reaches the configuration words through a word-addressed port. Writes are synchronous and reads are combinational. The eight words sit in two groups of four, and each group has its own base word address. A UART that samples at 16x is given a count of ceil(f_src/16/rate)-1. A synchronous channel is given ceil(f_src/rate)-1.

Top module: `baud_gen_bank`

## Requirements
- R1: After reset, all eight configuration words read zero and every tick and clock output is low.
- R2: Generators 0-3 are at word addresses 0-3 and generators 4-7 are at word addresses 8-11. Every other address reads zero, and writes to it change nothing.
- R3: In a configuration word, bits 12:1 hold the count N, bit 16 is enable, bit 17 selects divide-by-16, and bits 19:18 select the source. All other bits read zero no matter what was written.
- R4: An enabled generator raises its tick for one system cycle on every (N+1)th counted source event. With N=0 the tick follows every counted event, so an internal source gives a tick that stays high.
- R5: The clock output changes state exactly in the cycles in which the tick is high, which gives a 50% duty at f_src/(2(N+1)).
- R6: In the cycle after the enable bit reads clear, the tick and clock outputs of that generator are low. When the generator is enabled again, it counts from zero with its clock output low.
- R7: When bit 17 is set, only every 16th source event reaches the N+1 counter.
- R8: Source code 00 counts every system cycle, 01 counts rising edges of ext_clk_a, 10 counts rising edges of ext_clk_b, and 11 counts like 00. An external pin first sampled high at clock edge k, after having been low at edge k-1, is counted at edge k+2.
- R9: When a word is rewritten while its generator runs, the new count, prescale and source take effect only after the generator's next terminal count. The period in progress finishes with the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the addressed word |
| addr | input | ADDR_W (4) | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the addressed word |
| ext_clk_a | input | 1 | External clock pin A (asynchronous) |
| ext_clk_b | input | 1 | External clock pin B (asynchronous) |
| tick_o | output | NUM_GEN (8) | Per-generator single-cycle tick |
| clk_o | output | NUM_GEN (8) | Per-generator square clock |

## Verification
The bench aims at four corner cases.

- **Count of zero on the internal source.** A generator that mishandles it would pulse its tick every other cycle instead of holding it high.
- **Rewrite in the middle of a period.** A design that reloads immediately would cut the running period short, and the reference model would see a tick that comes early.
- **Words with all reserved bits set, and writes to unmapped addresses.** These would surface as stray readback bits or as corruption of a neighbouring generator.
- **External edges and the divide-by-16 path.** Here a latency error of one synchronizer stage, or a prescaler that wraps at 15 instead of 16, would shift every tick away from the cycle the model predicts.

// File: rtl/baud_pkg.sv
package baud_pkg;
    parameter int CNT_W   = 12;
    parameter int PRE_W   = 4;
    parameter int DIV_LSB = 1;
    parameter int EN_BIT  = 16;
    parameter int PRE_BIT = 17;
    parameter int SRC_LSB = 18;

    typedef enum logic [1:0] {
        SRC_INT  = 2'b00,
        SRC_EXTA = 2'b01,
        SRC_EXTB = 2'b10,
        SRC_RSVD = 2'b11
    } src_e;

    typedef struct packed {
        logic             en;
        logic             div16;
        src_e             src;
        logic [CNT_W-1:0] div;
    } cfg_t;

    function automatic cfg_t cfg_from_word(input logic [31:0] w);
        cfg_t c;
        c.en    = w[EN_BIT];
        c.div16 = w[PRE_BIT];
        c.src   = src_e'(w[SRC_LSB +: 2]);
        c.div   = w[DIV_LSB +: CNT_W];
        return c;
    endfunction

    function automatic logic [31:0] cfg_to_word(input cfg_t c);
        logic [31:0] w;
        w = '0;
        w[EN_BIT]             = c.en;
        w[PRE_BIT]            = c.div16;
        w[SRC_LSB +: 2]       = c.src;
        w[DIV_LSB +: CNT_W]   = c.div;
        return w;
    endfunction
endpackage

// File: rtl/baud_edge_sync.sv
module baud_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = pin_i;
        sync_d.s2 = sync_q.s1;
        sync_d.s3 = sync_q.s2;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign rise_o = sync_q.s2 & ~sync_q.s3;
endmodule

// File: rtl/baud_chan.sv
module baud_chan
    import baud_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  cfg_t cfg_i,
    input  logic int_evt_i,
    input  logic exta_evt_i,
    input  logic extb_evt_i,
    output logic tick_o,
    output logic clk_o
);
    typedef struct packed {
        logic             run;
        cfg_t             act;
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] cnt;
        logic             tick;
        logic             clk;
    } chan_t;

    chan_t st_d, st_q;
    cfg_t  eff;
    logic  evt;
    logic  stage;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        eff       = st_q.run ? st_q.act : cfg_i;
        evt       = 1'b0;
        stage     = 1'b0;
        if (!cfg_i.en) begin
            st_d.run = 1'b0;
            st_d.pre = '0;
            st_d.cnt = '0;
            st_d.clk = 1'b0;
        end else begin
            st_d.run = 1'b1;
            st_d.act = eff;
            case (eff.src)
                SRC_EXTA: evt = exta_evt_i;
                SRC_EXTB: evt = extb_evt_i;
                default:  evt = int_evt_i;
            endcase
            if (eff.div16) begin
                stage = evt && (st_q.pre == {PRE_W{1'b1}});
                if (evt) st_d.pre = st_q.pre + 1'b1;
            end else begin
                stage = evt;
            end
            if (stage) begin
                if (st_q.cnt == eff.div) begin
                    st_d.cnt  = '0;
                    st_d.tick = 1'b1;
                    st_d.clk  = ~st_q.clk;
                    st_d.act  = cfg_i;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o = st_q.tick;
    assign clk_o  = st_q.clk;
endmodule

// File: rtl/baud_gen_bank.sv
module baud_gen_bank
    import baud_pkg::*;
#(
    parameter int NUM_GEN    = 8,
    parameter int GROUP_SIZE = 4,
    parameter int ADDR_W     = 4,
    parameter int GRP_A_BASE = 0,
    parameter int GRP_B_BASE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              ext_clk_a,
    input  logic              ext_clk_b,
    output logic [NUM_GEN-1:0] tick_o,
    output logic [NUM_GEN-1:0] clk_o
);
    function automatic logic [ADDR_W-1:0] gen_addr(input int i);
        if (i < GROUP_SIZE) return ADDR_W'(GRP_A_BASE + i);
        else                return ADDR_W'(GRP_B_BASE + i - GROUP_SIZE);
    endfunction

    cfg_t [NUM_GEN-1:0] regs_d, regs_q;
    logic [NUM_GEN-1:0] gen_en;
    logic               addr_hit;
    logic               exta_rise, extb_rise;

    always_comb begin
        regs_d   = regs_q;
        rdata    = '0;
        addr_hit = 1'b0;
        for (int i = 0; i < NUM_GEN; i++) begin
            if (addr == gen_addr(i)) begin
                addr_hit = 1'b1;
                rdata    = cfg_to_word(regs_q[i]);
                if (wr_en) regs_d[i] = cfg_from_word(wdata);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    baud_edge_sync u_sync_a (.clk(clk), .rst_n(rst_n), .pin_i(ext_clk_a), .rise_o(exta_rise));
    baud_edge_sync u_sync_b (.clk(clk), .rst_n(rst_n), .pin_i(ext_clk_b), .rise_o(extb_rise));

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_chan
        assign gen_en[g] = regs_q[g].en;
        baud_chan u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_i     (regs_q[g]),
            .int_evt_i (1'b1),
            .exta_evt_i(exta_rise),
            .extb_evt_i(extb_rise),
            .tick_o    (tick_o[g]),
            .clk_o     (clk_o[g])
        );
    end
endmodule

// File: rtl/baud_gen_bank_chk.sv
module baud_gen_bank_chk #(
    parameter int NUM_GEN = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [31:0]        rdata,
    input logic               addr_hit,
    input logic [NUM_GEN-1:0] gen_en,
    input logic [NUM_GEN-1:0] tick_o,
    input logic [NUM_GEN-1:0] clk_o
);
    localparam logic [31:0] LIVE_MASK = 32'h000F_1FFE;

    assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata & ~LIVE_MASK) == 32'h0);

    assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_hit |-> rdata == 32'h0);

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_chk
        assert_off_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !gen_en[g] |=> (!tick_o[g] && !clk_o[g]));

        assert_clk_follows_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
            gen_en[g] |=> ((clk_o[g] != $past(clk_o[g])) == tick_o[g]));
    end
endmodule

bind baud_gen_bank baud_gen_bank_chk #(.NUM_GEN(NUM_GEN)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rdata   (rdata),
    .addr_hit(addr_hit),
    .gen_en  (gen_en),
    .tick_o  (tick_o),
    .clk_o   (clk_o)
);

// File: tb/baud_gen_bank_test.sv
module baud_gen_bank_test;
    localparam int NG = 8;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0;
    logic [3:0]  addr = 0;
    logic [31:0] wdata = 0;
    logic [31:0] rdata;
    logic        ext_clk_a = 0;
    logic        ext_clk_b = 0;
    logic [NG-1:0] tick_o, clk_o;

    baud_gen_bank uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ext_clk_a(ext_clk_a), .ext_clk_b(ext_clk_b),
        .tick_o(tick_o), .clk_o(clk_o)
    );

    always #10 clk = ~clk;

    int    n_checks = 0;
    int    n_fail   = 0;
    int    cycles   = 0;
    string cur_req  = "R1";
    bit    done     = 0;

    // reference model state
    logic [31:0] mreg [NG];
    int  m_run [NG], m_cnt [NG], m_pre [NG];
    int  m_adiv [NG], m_apre [NG], m_asrc [NG];
    bit  m_tick [NG], m_clk [NG];
    bit  pa1, pa2, pa3, pb1, pb2, pb3;

    function automatic int idx_of(input logic [3:0] a);
        if (a < 4) return int'(a);
        if (a >= 8 && a < 12) return int'(a) - 4;
        return -1;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            for (int i = 0; i < NG; i++) begin
                mreg[i] = 0; m_run[i] = 0; m_cnt[i] = 0; m_pre[i] = 0;
                m_adiv[i] = 0; m_apre[i] = 0; m_asrc[i] = 0;
                m_tick[i] = 0; m_clk[i] = 0;
            end
            pa1 = 0; pa2 = 0; pa3 = 0; pb1 = 0; pb2 = 0; pb3 = 0;
        end else begin
            bit ra, rb;
            ra = pa2 && !pa3;
            rb = pb2 && !pb3;
            for (int i = 0; i < NG; i++) begin
                int  rdiv, rpre, rsrc;
                bit  ev, st;
                rdiv = int'((mreg[i] >> 1) & 32'hFFF);
                rpre = int'((mreg[i] >> 17) & 1);
                rsrc = int'((mreg[i] >> 18) & 3);
                m_tick[i] = 0;
                if (((mreg[i] >> 16) & 1) == 0) begin
                    m_run[i] = 0; m_cnt[i] = 0; m_pre[i] = 0; m_clk[i] = 0;
                end else begin
                    if (m_run[i] == 0) begin
                        m_adiv[i] = rdiv; m_apre[i] = rpre; m_asrc[i] = rsrc; m_run[i] = 1;
                    end
                    ev = (m_asrc[i] == 1) ? ra : (m_asrc[i] == 2) ? rb : 1'b1;
                    st = ev;
                    if (m_apre[i] != 0) begin
                        st = ev && (m_pre[i] == 15);
                        if (ev) m_pre[i] = (m_pre[i] + 1) % 16;
                    end
                    if (st) begin
                        if (m_cnt[i] == m_adiv[i]) begin
                            m_cnt[i] = 0; m_tick[i] = 1; m_clk[i] = !m_clk[i];
                            m_adiv[i] = rdiv; m_apre[i] = rpre; m_asrc[i] = rsrc;
                        end else m_cnt[i]++;
                    end
                end
            end
            if (wr_en && idx_of(addr) >= 0) mreg[idx_of(addr)] = wdata & 32'h000F_1FFE;
            pa3 = pa2; pa2 = pa1; pa1 = ext_clk_a;
            pb3 = pb2; pb2 = pb1; pb1 = ext_clk_b;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        #8;
        if (!done) begin
            logic [31:0] er;
            er = (idx_of(addr) >= 0) ? mreg[idx_of(addr)] : 32'h0;
            check(rdata == er, (idx_of(addr) >= 0) ? cur_req : "R2", "rdata", rdata, er);
            for (int i = 0; i < NG; i++) begin
                check(tick_o[i] == m_tick[i], cur_req, $sformatf("tick[%0d]", i),
                      32'(tick_o[i]), 32'(m_tick[i]));
                check(clk_o[i] == m_clk[i], (cur_req == "R1") ? "R1" : "R5",
                      $sformatf("clk[%0d]", i), 32'(clk_o[i]), 32'(m_clk[i]));
            end
        end
    end

    // external pin stimulus (each level held for at least two cycles)
    int ca = 0, cb = 0;
    always @(negedge clk) begin
        ca++; cb++;
        if (ca == 3) begin ca = 0; ext_clk_a <= !ext_clk_a; end
        if (cb == 5) begin cb = 0; ext_clk_b <= !ext_clk_b; end
    end

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic sweep();
        for (int a = 0; a < 16; a++) begin
            @(negedge clk);
            addr = 4'(a);
        end
    endtask

    initial begin
        cur_req = "R1";
        idle(4);
        rst_n = 1;
        sweep();                              // R1: all words zero
        cur_req = "R3";
        wr(4'd3, 32'hFFFE_E001);              // R3: reserved bits dropped, disabled
        sweep();
        cur_req = "R2";
        wr(4'd4, 32'hFFFF_FFFF); wr(4'd7, 32'hFFFF_FFFF);
        wr(4'd12, 32'hFFFF_FFFF); wr(4'd15, 32'hFFFF_FFFF);
        sweep();                              // R2: unmapped ignored, neighbours intact
        cur_req = "R4";
        wr(4'd0, 32'h0001_0000);              // count 0, internal
        wr(4'd1, 32'h0001_0008);              // count 4, internal
        idle(60);
        cur_req = "R7";
        wr(4'd9, 32'h0003_0004);              // div16, count 2
        idle(200);
        cur_req = "R8";
        wr(4'd10, 32'h0005_0002);             // ext A, count 1
        wr(4'd11, 32'h0009_0000);             // ext B, count 0
        wr(4'd2, 32'h000D_0006);              // reserved source code, count 3
        idle(150);
        cur_req = "R9";
        idle(2);
        wr(4'd1, 32'h0001_0012);              // count 9, applied after next terminal
        wr(4'd9, 32'h0001_0002);              // drop prescale, deferred
        idle(120);
        cur_req = "R6";
        wr(4'd1, 32'h0000_0012);              // disable
        idle(20);
        wr(4'd1, 32'h0001_0012);              // re-enable, restart from zero
        wr(4'd10, 32'h0000_0002);
        idle(60);
        sweep();
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        wait (cycles > 50000);
        if (!done) begin
            done = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog %s actual %0d expected %0d", cur_req, cycles, 50000);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule